// File: doc/BRIEF.md
# Flash Controller Event Status and Interrupt Unit

This block gathers six event sources from a flash memory controller and offers them to software in two forms. The first is a live condition word. It mirrors the present state of the flash device and the controller: ready levels, decoder failure, and an encoded count of corrected symbols. The second is a sticky event word. Each bit latches a one-cycle event pulse and stays set until software reads the word. That read returns the word and clears it in the same access.

A mask register selects which sticky bits drive a single active-high, level-sensitive interrupt line. Software reaches the three registers through a simple port with an address, a read strobe, a write strobe and write data. Read data is registered and appears on the cycle after the read strobe.

Top module: `flash_evt_status`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets sticky bit i, and the bit then holds until a sticky read clears it. The bit meanings are: 0 write-protect fault, 1 ECC ready, 2 decode error, 3 decode failure, 4 controller ready, 5 flash ready.
- R2: Address 1 is the mask register. A write loads bits [5:0] from `reg_wdata`, using the same bit meanings as the sticky word. A read returns the mask with bits [7:6] at zero.
- R3: A read of address 2 returns the sticky word and clears every bit that it returned.
- R4: An event pulse in the same cycle as a clearing read leaves its bit set after the read. The value returned by that read does not include the new event.
- R5: `irq` is high exactly while some sticky bit and its mask bit are both 1.
- R6: A read of address 0 returns the live condition word. Its layout is: bit 0 flash ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits [5:4] error count, bit 6 decoder failure, bit 7 zero.
- R7: When `lvl_corr_cnt` is n > 0, bit 3 is 1 and bits [5:4] hold n-1. When n = 0, bit 3 and bits [5:4] are all zero.
- R8: A corrected count above 4 saturates bits [5:4] to 3.
- R9: Writes to addresses 0, 2 and 3 change neither the mask nor the sticky word.
- R10: After reset, the sticky word, the mask and `reg_rdata` are zero and `irq` is low.
- R11: `reg_rdata` changes only on the cycle after `reg_rd` and otherwise holds. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 6 | One-cycle event pulses, one per sticky bit |
| lvl_flash_ready | input | 1 | Live flash device ready level |
| lvl_ctrl_ready | input | 1 | Live controller ready level |
| lvl_ecc_ready | input | 1 | Live ECC ready level |
| lvl_dec_fail | input | 1 | Live decoder failure level |
| lvl_corr_cnt | input | 3 | Number of symbols corrected in the last decode |
| reg_addr | input | 2 | Register select: 0 live, 1 mask, 2 sticky |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions take the port signals as synchronous to `clk` and stable across each rising edge. They place no limit on how events and register accesses combine: a pulse may land on any bit in any cycle, including one that carries a clearing read or a mask write. The stimulus is therefore driven only on falling edges. Its directed phase lines pulses up against reads, and a long random phase covers every overlap of pulses, reads and writes on all four addresses.

// File: rtl/flash_evt_pkg.sv
// Shared constants and types for the flash event status unit.
// Assumes a byte-wide register port and a six-source sticky word.
package flash_evt_pkg;
    localparam int EVT_N  = 6;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // sticky / mask bit meanings
    localparam int EB_WP_FAULT   = 0;
    localparam int EB_ECC_RDY    = 1;
    localparam int EB_DEC_ERR    = 2;
    localparam int EB_DEC_FAIL   = 3;
    localparam int EB_CTRL_RDY   = 4;
    localparam int EB_FLASH_RDY  = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_LIVE   = 2'd0,
        RA_MASK   = 2'd1,
        RA_STICKY = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/fes_sticky_bank.sv
// Sticky event flags: each bit latches a one-cycle pulse and holds it
// until a clearing read. A pulse in the clearing cycle survives.
// Assumes clr is a single-cycle strobe aligned with the read.
module fes_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // per-bit set-dominant flag with clear-on-read
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else
                    flags[i] <= evt[i] | (flags[i] & ~clr);
            end
        end
    endgenerate

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((flags & ~$past(evt)) == '0)); // R3
    AST_EVENT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && evt == '0) |=> $stable(flags)); // R1
endmodule

// File: rtl/fes_mask_reg.sv
// Interrupt enable mask: loads on a decoded write, otherwise holds.
// Assumes load is already qualified by address decode.
module fes_mask_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] din,
    output logic [N-1:0] mask
);
    // mask storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (load)
            mask <= din;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mask == $past(din))); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask)); // R9
endmodule

// File: rtl/fes_live_view.sv
// Builds the live condition word from present levels, encoding the
// corrected-symbol count as count-1 with saturation at the field maximum.
// Assumes the count input is one bit wider than the field.
module fes_live_view #(
    parameter int CNT_W = 2,
    parameter int REG_W = 8
) (
    input  logic             flash_rdy,
    input  logic             ctrl_rdy,
    input  logic             ecc_rdy,
    input  logic             dec_fail,
    input  logic [CNT_W:0]   corr_cnt,
    output logic [REG_W-1:0] word
);
    localparam int          FIELD_LO  = 4;
    localparam int          FAIL_BIT  = FIELD_LO + CNT_W;
    localparam logic [CNT_W:0] CNT_CAP = (CNT_W+1)'(1 << CNT_W);

    logic             err_seen;
    logic [CNT_W-1:0] field;

    // count encoding: zero when clean, n-1 otherwise, capped
    always_comb begin
        err_seen = (corr_cnt != '0);
        if (!err_seen)
            field = '0;
        else if (corr_cnt > CNT_CAP)
            field = '1;
        else
            field = CNT_W'(corr_cnt - 1'b1);
    end

    // word assembly
    always_comb begin
        word = '0;
        word[0] = flash_rdy;
        word[1] = ctrl_rdy;
        word[2] = ecc_rdy;
        word[3] = err_seen;
        word[FIELD_LO +: CNT_W] = field;
        word[FAIL_BIT] = dec_fail;
    end
endmodule

// File: rtl/flash_evt_status.sv
// Top of the flash event status unit: register decode, read mux with
// registered read data, sticky clear on read, and masked level interrupt.
// Assumes single-cycle strobes on reg_rd and reg_wr, synchronous to clk.
module flash_evt_status
    import flash_evt_pkg::*;
#(
    parameter int CNT_W  = 2,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic              lvl_flash_ready,
    input  logic              lvl_ctrl_ready,
    input  logic              lvl_ecc_ready,
    input  logic              lvl_dec_fail,
    input  logic [CNT_W:0]    lvl_corr_cnt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [EVT_N-1:0]  flags;
    logic [EVT_N-1:0]  mask;
    logic [DATA_W-1:0] live_word;
    logic              sticky_clr;
    logic              mask_load;
    logic [DATA_W-1:0] rd_mux;

    // address decode for side effects
    always_comb begin
        sticky_clr = reg_rd && (reg_addr == RA_STICKY);
        mask_load  = reg_wr && (reg_addr == RA_MASK);
    end

    fes_sticky_bank #(.N(EVT_N)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_pulse),
        .clr   (sticky_clr),
        .flags (flags)
    );

    fes_mask_reg #(.N(EVT_N)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mask_load),
        .din   (reg_wdata[EVT_N-1:0]),
        .mask  (mask)
    );

    fes_live_view #(.CNT_W(CNT_W), .REG_W(DATA_W)) u_live (
        .flash_rdy (lvl_flash_ready),
        .ctrl_rdy  (lvl_ctrl_ready),
        .ecc_rdy   (lvl_ecc_ready),
        .dec_fail  (lvl_dec_fail),
        .corr_cnt  (lvl_corr_cnt),
        .word      (live_word)
    );

    // read data selection
    always_comb begin
        unique case (reg_addr)
            RA_LIVE:   rd_mux = live_word;
            RA_MASK:   rd_mux = DATA_W'(mask);
            RA_STICKY: rd_mux = DATA_W'(flags);
            default:   rd_mux = '0;
        endcase
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    // level interrupt from enabled sticky bits
    always_comb irq = |(flags & mask);

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt_pulse) || $past(mask_load))); // R5
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_rdata == '0 && !irq)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11
endmodule

// File: tb/flash_evt_status_test.sv
module flash_evt_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_pulse = '0;
    logic       lvl_flash_ready = 1'b0;
    logic       lvl_ctrl_ready = 1'b0;
    logic       lvl_ecc_ready = 1'b0;
    logic       lvl_dec_fail = 1'b0;
    logic [2:0] lvl_corr_cnt = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_sticky = 0;
    int m_mask = 0;
    int m_rdata = 0;

    flash_evt_status uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .lvl_flash_ready(lvl_flash_ready), .lvl_ctrl_ready(lvl_ctrl_ready),
        .lvl_ecc_ready(lvl_ecc_ready), .lvl_dec_fail(lvl_dec_fail),
        .lvl_corr_cnt(lvl_corr_cnt), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic int live_ref();
        int v;
        int n;
        n = lvl_corr_cnt;
        v = 0;
        if (lvl_flash_ready) v += 1;
        if (lvl_ctrl_ready)  v += 2;
        if (lvl_ecc_ready)   v += 4;
        if (n > 0) begin
            v += 8;
            v += ((n > 4) ? 3 : n - 1) * 16;
        end
        if (lvl_dec_fail) v += 64;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model update at each edge, then compare every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sticky = 0; m_mask = 0; m_rdata = 0;
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: m_rdata = live_ref();
                    2'd1: m_rdata = m_mask;
                    2'd2: m_rdata = m_sticky;
                    default: m_rdata = 0;
                endcase
            end
            if (reg_rd && reg_addr == 2'd2) m_sticky = 0;
            m_sticky = m_sticky | int'(evt_pulse);
            if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata[5:0]);
        end
        #2;
        if (!done) begin
            chk("R11 rdata vs model", int'(reg_rdata), m_rdata);
            chk("R5 irq vs model", int'(irq), ((m_sticky & m_mask) != 0) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk); evt_pulse = v;
        @(negedge clk); evt_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [5:0] ev, output int val);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; evt_pulse = ev;
        @(negedge clk); reg_rd = 1'b0; evt_pulse = '0;
        val = int'(reg_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state
        chk("R10 rdata after reset", int'(reg_rdata), 0);
        chk("R10 irq after reset", int'(irq), 0);
        rd(2'd1, 6'h0, v); chk("R10 mask zero", v, 0);
        rd(2'd2, 6'h0, v); chk("R10 sticky zero", v, 0);

        // R1 / R3: write-protect fault latches, clears on read
        pulse(6'h01); idle(2);
        rd(2'd2, 6'h0, v); chk("R1 wp fault bit 0", v, 8'h01);
        rd(2'd2, 6'h0, v); chk("R3 cleared by read", v, 0);
        pulse(6'h08);
        rd(2'd2, 6'h0, v); chk("R1 decode failure bit 3", v, 8'h08);

        // R2 mask readback
        wr(2'd1, 8'hFF);
        rd(2'd1, 6'h0, v); chk("R2 mask upper bits zero", v, 8'h3F);
        chk("R5 no sticky no irq", int'(irq), 0);

        // R5 masked interrupt
        pulse(6'h10);
        chk("R5 irq raised", int'(irq), 1);
        rd(2'd2, 6'h0, v); chk("R1 controller ready bit 4", v, 8'h10);
        chk("R5 irq dropped after clear", int'(irq), 0);
        wr(2'd1, 8'h01);
        pulse(6'h20);
        chk("R5 masked source silent", int'(irq), 0);
        rd(2'd2, 6'h0, v); chk("R1 flash ready bit 5", v, 8'h20);

        // R4 event coincident with clearing read
        pulse(6'h02);
        rd(2'd2, 6'h04, v); chk("R4 read excludes new event", v, 8'h02);
        rd(2'd2, 6'h0, v); chk("R4 new event kept", v, 8'h04);

        // R6 / R7 / R8 live word
        @(negedge clk);
        lvl_flash_ready = 1; lvl_ctrl_ready = 0; lvl_ecc_ready = 1;
        lvl_dec_fail = 1; lvl_corr_cnt = 3'd3;
        rd(2'd0, 6'h0, v); chk("R6 live layout", v, 8'h6D);
        lvl_flash_ready = 0; lvl_ctrl_ready = 1; lvl_ecc_ready = 0;
        lvl_dec_fail = 0; lvl_corr_cnt = 3'd1;
        rd(2'd0, 6'h0, v); chk("R7 one correction", v, 8'h0A);
        lvl_ctrl_ready = 0; lvl_corr_cnt = 3'd0;
        rd(2'd0, 6'h0, v); chk("R7 no correction", v, 8'h00);
        lvl_corr_cnt = 3'd4;
        rd(2'd0, 6'h0, v); chk("R7 four corrections", v, 8'h38);
        lvl_corr_cnt = 3'd7;
        rd(2'd0, 6'h0, v); chk("R8 saturated count", v, 8'h38);
        lvl_corr_cnt = 3'd0;

        // R9 writes elsewhere ignored
        wr(2'd1, 8'h15);
        pulse(6'h08);
        wr(2'd0, 8'hFF); wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
        rd(2'd1, 6'h0, v); chk("R9 mask untouched", v, 8'h15);
        rd(2'd2, 6'h0, v); chk("R9 sticky untouched", v, 8'h08);

        // R11 hold and unused address
        idle(4); chk("R11 rdata holds", int'(reg_rdata), 8'h08);
        rd(2'd3, 6'h0, v); chk("R11 address 3 reads zero", v, 0);

        // random phase against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            evt_pulse = ($urandom % 3 == 0) ? 6'($urandom) : 6'h0;
            reg_addr = 2'($urandom);
            reg_rd = ($urandom % 3 == 0);
            reg_wr = ($urandom % 4 == 0);
            reg_wdata = 8'($urandom);
            lvl_flash_ready = 1'($urandom); lvl_ctrl_ready = 1'($urandom);
            lvl_ecc_ready = 1'($urandom); lvl_dec_fail = 1'($urandom);
            lvl_corr_cnt = 3'($urandom);
        end
        @(negedge clk);
        evt_pulse = '0; reg_rd = 0; reg_wr = 0;
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule